// File: doc/BRIEF.md
# Reference-Counted Clamp Release Sequencer

This block controls the isolation of a switchable power domain through three control outputs: a core-supply-off bit, an early clamp bit and a main clamp bit. All three come out of reset set, so the domain starts clamped and unpowered. Several clients share the domain. Each client sends a one-cycle enable pulse when it needs the domain and a one-cycle disable pulse when it is done. The block keeps a count of active clients.

When the count goes from zero to one, the block runs the release sequence. It clears the main clamp, waits a settling time, clears the early clamp, waits again, and then clears the core-supply-off bit. When the count goes from one to zero, it runs the apply sequence, which is the same steps in reverse order. Any other enable or disable only changes the count. A disable that arrives when the count is already zero raises a one-cycle underflow flag and has no other effect.

The settling time is a parameter in clock cycles. A busy flag is high while a sequence runs. A request that arrives during a sequence is held, one deep for each kind, and is served after the sequence ends. If both kinds are waiting, the enable is served first.

Top module: `pwr_clamp_seq`

## Requirements
- R1: During reset and after it, vcore_down_o, early_clamp_o and clamp_o are 1, and busy_o and underflow_o are 0. The client count returns to zero, and any held request is dropped.
- R2: Release timing. Suppose an enable pulse is sampled at clock edge A while the count is zero and the block is idle. Then clamp_o falls at edge A+1. early_clamp_o falls at edge A+1+S, where S is SETTLE_CYCLES. vcore_down_o falls at edge A+1+2S. busy_o is 1 from edge A+1 until edge A+1+2S, when it returns to 0.
- R3: Apply timing. Suppose a disable pulse is sampled at edge A while the count is one and the block is idle. Then vcore_down_o rises at edge A+1, early_clamp_o rises at A+1+S, and clamp_o rises at A+1+2S. busy_o follows the same window as in R2.
- R4: An enable while the count is already nonzero only increments the count. No output changes, and busy_o stays 0.
- R5: A disable that leaves the count above zero only decrements the count. No output changes, and busy_o stays 0.
- R6: A disable while the count is zero sets underflow_o for exactly one cycle, at the edge where the request would have been served. The control bits and the count do not change.
- R7: A request that arrives while busy_o is 1 is held and served at the first edge after busy_o falls. If an enable and a disable are both waiting, the enable is served first and the disable at the next idle edge.
- R8: At most one of the three control bits changes on any clock edge.
- R9: Whenever busy_o is 0, the three control bits are either all 1 or all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req_i | input | 1 | One-cycle enable request from a client |
| dis_req_i | input | 1 | One-cycle disable request from a client |
| vcore_down_o | output | 1 | Core supply off control, 1 = off |
| early_clamp_o | output | 1 | Early clamp control, 1 = clamped |
| clamp_o | output | 1 | Main clamp control, 1 = clamped |
| busy_o | output | 1 | A release or apply sequence is running |
| underflow_o | output | 1 | One-cycle flag: a disable arrived while the count was zero |

## Verification
The hardest situation to create from the ports is a request that arrives during a sequence. The clearest case is a disable that arrives in the middle of a release, where the block must hold the disable and then start an apply on the first idle edge. The stimulus reaches this state by pulsing a disable one cycle after a first enable has started the release. It then follows busy_o down and checks that the apply starts exactly one edge later. A second test pulses enable and disable in the same cycle from a count of zero, which checks that the enable is served first. Short settling windows make it practical to check each intermediate step cycle by cycle.

// File: rtl/pcs_pkg.sv
// Shared types for the clamp release sequencer.
// Assumes three control bits in a fixed order: {vcore_down, early_clamp, clamp}.
package pcs_pkg;

    // Sequencer states: idle, the two waits of a release, the two waits of an apply.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REL_A = 3'd1,
        ST_REL_B = 3'd2,
        ST_APP_A = 3'd3,
        ST_APP_B = 3'd4
    } step_e;

    // The three isolation controls, 1 = isolated / unpowered.
    typedef struct packed {
        logic vcore_down;
        logic early_clamp;
        logic clamp;
    } iso_ctl_t;

    localparam iso_ctl_t CTL_SAFE = '{vcore_down: 1'b1, early_clamp: 1'b1, clamp: 1'b1};
    localparam iso_ctl_t CTL_LIVE = '{vcore_down: 1'b0, early_clamp: 1'b0, clamp: 1'b0};

endpackage

// File: rtl/pcs_settle_timer.sv
// Down-counter for the settling wait between sequence steps.
// After load is seen at an edge, expired_o rises SETTLE_CYCLES-1 edges later.
// A step taken on expiry therefore lands SETTLE_CYCLES edges after the load.
// Assumes SETTLE_CYCLES >= 1.
module pcs_settle_timer #(
    parameter int SETTLE_CYCLES = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int TMR_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [TMR_W-1:0] LOAD_VAL = TMR_W'(SETTLE_CYCLES - 1);

    logic [TMR_W-1:0] remain_q;

    // Reload on request; otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= LOAD_VAL;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // The wait is over once the count has reached zero.
    assign expired_o = (remain_q == '0);

endmodule

// File: rtl/pcs_req_tracker.sv
// Holds pending requests and the client count, and decides the start of each sequence.
// A request is held one deep per kind and is taken only while the engine is idle.
// An enable is taken before a disable. Only a count change 0->1 or 1->0 starts a sequence.
// Assumes no more than MAX_CLIENTS active clients; the count holds at that limit.
module pcs_req_tracker #(
    parameter int MAX_CLIENTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req_i,
    input  logic dis_req_i,
    input  logic engine_idle_i,
    output logic start_rel_o,
    output logic start_app_o,
    output logic underflow_o
);
    localparam int CNT_W = $clog2(MAX_CLIENTS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CLIENTS);

    logic             pend_en_q;
    logic             pend_dis_q;
    logic [CNT_W-1:0] users_q;
    logic             uflow_q;
    logic             take_en;
    logic             take_dis;
    logic             cnt_zero;

    // Arbitration: the engine must be idle, and enable wins over disable.
    always_comb begin
        take_en  = engine_idle_i && pend_en_q;
        take_dis = engine_idle_i && pend_dis_q && !pend_en_q;
        cnt_zero = (users_q == '0);
    end

    // Hold requests, update the client count and raise the underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_en_q  <= 1'b0;
            pend_dis_q <= 1'b0;
            users_q    <= '0;
            uflow_q    <= 1'b0;
        end else begin
            pend_en_q  <= en_req_i  || (pend_en_q  && !take_en);
            pend_dis_q <= dis_req_i || (pend_dis_q && !take_dis);
            uflow_q    <= take_dis && cnt_zero;
            if (take_en && users_q != CNT_MAX) begin
                users_q <= users_q + 1'b1;
            end else if (take_dis && !cnt_zero) begin
                users_q <= users_q - 1'b1;
            end
        end
    end

    // Start a sequence only when the count leaves or reaches zero.
    always_comb begin
        start_rel_o = take_en && cnt_zero;
        start_app_o = take_dis && (users_q == CNT_W'(1));
    end

    assign underflow_o = uflow_q;

    AST_UFLOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_q |-> ($past(users_q) == '0 && $stable(users_q))) else $error("underflow with nonzero count"); // R6

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_rel_o && start_app_o)) else $error("two starts at once"); // R7

endmodule

// File: rtl/pcs_step_engine.sv
// Steps the three isolation bits through a release or an apply sequence.
// Release order: clamp, early clamp, core supply. Apply order is the reverse.
// One settling wait separates neighbouring steps.
// Assumes start requests arrive only while idle, and never both at once.
module pcs_step_engine
    import pcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_rel_i,
    input  logic     start_app_i,
    input  logic     expired_i,
    output logic     load_o,
    output iso_ctl_t ctl_o,
    output logic     busy_o,
    output logic     idle_o
);
    step_e    state_q, state_d;
    iso_ctl_t ctl_q, ctl_d;

    // Next-state logic: take one step per start or per expired wait.
    always_comb begin
        state_d = state_q;
        ctl_d   = ctl_q;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rel_i) begin
                    ctl_d.clamp = 1'b0;
                    state_d     = ST_REL_A;
                    load_o      = 1'b1;
                end else if (start_app_i) begin
                    ctl_d.vcore_down = 1'b1;
                    state_d          = ST_APP_A;
                    load_o           = 1'b1;
                end
            end
            ST_REL_A: begin
                if (expired_i) begin
                    ctl_d.early_clamp = 1'b0;
                    state_d           = ST_REL_B;
                    load_o            = 1'b1;
                end
            end
            ST_REL_B: begin
                if (expired_i) begin
                    ctl_d.vcore_down = 1'b0;
                    state_d          = ST_IDLE;
                end
            end
            ST_APP_A: begin
                if (expired_i) begin
                    ctl_d.early_clamp = 1'b1;
                    state_d           = ST_APP_B;
                    load_o            = 1'b1;
                end
            end
            ST_APP_B: begin
                if (expired_i) begin
                    ctl_d.clamp = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                ctl_d   = CTL_SAFE;
            end
        endcase
    end

    // State and control registers; reset leaves the domain isolated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_SAFE;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
        end
    end

    // Status outputs decoded from the registered state.
    assign ctl_o  = ctl_q;
    assign busy_o = (state_q != ST_IDLE);
    assign idle_o = (state_q == ST_IDLE);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rel_i || start_app_i) |-> (state_q == ST_IDLE)) else $error("start while busy"); // R7

    AST_REL_ORDER_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.early_clamp) |-> !ctl_q.clamp && ctl_q.vcore_down) else $error("release order"); // R2

    AST_REL_ORDER_VCORE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.vcore_down) |-> !ctl_q.clamp && !ctl_q.early_clamp) else $error("release order"); // R2

    AST_APP_ORDER_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.early_clamp) |-> ctl_q.vcore_down && !ctl_q.clamp) else $error("apply order"); // R3

    AST_APP_ORDER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.clamp) |-> ctl_q.vcore_down && ctl_q.early_clamp) else $error("apply order"); // R3

    AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl_q ^ $past(ctl_q)) <= 1) else $error("several bits changed"); // R8

    AST_IDLE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ctl_q == CTL_SAFE || ctl_q == CTL_LIVE)) else $error("idle in mixed state"); // R9

endmodule

// File: rtl/pwr_clamp_seq.sv
// Top level of the reference-counted clamp release sequencer.
// Connects the request tracker, the step engine and the settle timer.
// Assumes one-cycle request pulses, a synchronous active-low reset, and SETTLE_CYCLES >= 1.
module pwr_clamp_seq #(
    parameter int SETTLE_CYCLES = 15000,
    parameter int MAX_CLIENTS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req_i,
    input  logic dis_req_i,
    output logic vcore_down_o,
    output logic early_clamp_o,
    output logic clamp_o,
    output logic busy_o,
    output logic underflow_o
);
    import pcs_pkg::*;

    logic     start_rel;
    logic     start_app;
    logic     eng_idle;
    logic     tmr_load;
    logic     tmr_expired;
    iso_ctl_t ctl;

    pcs_req_tracker #(
        .MAX_CLIENTS (MAX_CLIENTS)
    ) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_req_i      (en_req_i),
        .dis_req_i     (dis_req_i),
        .engine_idle_i (eng_idle),
        .start_rel_o   (start_rel),
        .start_app_o   (start_app),
        .underflow_o   (underflow_o)
    );

    pcs_step_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_rel_i (start_rel),
        .start_app_i (start_app),
        .expired_i   (tmr_expired),
        .load_o      (tmr_load),
        .ctl_o       (ctl),
        .busy_o      (busy_o),
        .idle_o      (eng_idle)
    );

    pcs_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    // Split the control struct onto the output pins.
    assign vcore_down_o  = ctl.vcore_down;
    assign early_clamp_o = ctl.early_clamp;
    assign clamp_o       = ctl.clamp;

    AST_UFLOW_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> $stable(ctl) && !busy_o) else $error("underflow moved bits"); // R6

endmodule

// File: tb/test_pwr_clamp_seq.sv
module test_pwr_clamp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int S          = 4;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0;
    logic dis_req = 1'b0;
    logic vcore_down, early_clamp, clamp, busy, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_clamp_seq #(.SETTLE_CYCLES(S), .MAX_CLIENTS(8)) i_pwr_clamp_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_req_i      (en_req),
        .dis_req_i     (dis_req),
        .vcore_down_o  (vcore_down),
        .early_clamp_o (early_clamp),
        .clamp_o       (clamp),
        .busy_o        (busy),
        .underflow_o   (underflow)
    );

    // Vector fields: [5] 1=enable 0=disable, [4] sequence starts, [3] underflow,
    // [2:0] bits after completion, in the order {vcore_down, early_clamp, clamp}.
    localparam logic [5:0] VEC [11] = '{
        6'b1_1_0_000,  // first enable: release (R2)
        6'b1_0_0_000,  // nested enable (R4)
        6'b0_0_0_000,  // disable leaving one (R5)
        6'b0_1_0_111,  // last disable: apply (R3)
        6'b0_0_1_111,  // disable at zero (R6)
        6'b1_1_0_000,  // enable after underflow: count still zero (R6)
        6'b1_0_0_000,
        6'b1_0_0_000,
        6'b0_0_0_000,
        6'b0_0_0_000,
        6'b0_1_0_111   // back to zero (R3)
    };

    function automatic logic [2:0] bits();
        return {vcore_down, early_clamp, clamp};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic e, input logic d);
        @(negedge clk);
        en_req  = e;
        dis_req = d;
        @(negedge clk);
        en_req  = 1'b0;
        dis_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R1..): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bits in reset", 32'(bits()), 32'h7);
        chk("R1 busy in reset", 32'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bits after reset", 32'(bits()), 32'h7);
        chk("R1 underflow after reset", 32'(underflow), 0);

        // R2 and R8: release, step by step
        pulse(1'b1, 1'b0);
        @(negedge clk);
        chk("R2 step1 bits", 32'(bits()), 32'h6);
        chk("R2 step1 busy", 32'(busy), 1);
        repeat (S - 1) @(negedge clk);
        chk("R8 wait1 held", 32'(bits()), 32'h6);
        @(negedge clk);
        chk("R2 step2 bits", 32'(bits()), 32'h4);
        repeat (S - 1) @(negedge clk);
        chk("R8 wait2 held", 32'(bits()), 32'h4);
        chk("R2 busy in wait2", 32'(busy), 1);
        @(negedge clk);
        chk("R2 step3 bits", 32'(bits()), 32'h0);
        chk("R2 busy end", 32'(busy), 0);

        // R3: apply, step by step
        pulse(1'b0, 1'b1);
        @(negedge clk);
        chk("R3 step1 bits", 32'(bits()), 32'h4);
        chk("R3 step1 busy", 32'(busy), 1);
        repeat (S - 1) @(negedge clk);
        chk("R3 wait1 held", 32'(bits()), 32'h4);
        @(negedge clk);
        chk("R3 step2 bits", 32'(bits()), 32'h6);
        repeat (S) @(negedge clk);
        chk("R3 step3 bits", 32'(bits()), 32'h7);
        chk("R3 busy end", 32'(busy), 0);

        // Table walk: R4, R5, R6, R9
        foreach (VEC[k]) begin
            pulse(VEC[k][5], !VEC[k][5]);
            @(negedge clk);
            chk($sformatf("R4/R5 row %0d busy", k), 32'(busy), 32'(VEC[k][4]));
            chk($sformatf("R6 row %0d underflow", k), 32'(underflow), 32'(VEC[k][3]));
            if (VEC[k][4]) repeat (2 * S) @(negedge clk);
            chk($sformatf("R9 row %0d bits", k), 32'(bits()), 32'(VEC[k][2:0]));
            chk($sformatf("R9 row %0d idle", k), 32'(busy), 0);
        end

        // R6: underflow lasts one cycle
        pulse(1'b0, 1'b1);
        @(negedge clk);
        chk("R6 underflow set", 32'(underflow), 1);
        chk("R6 bits kept", 32'(bits()), 32'h7);
        @(negedge clk);
        chk("R6 underflow one cycle", 32'(underflow), 0);

        // R7: disable held during a release, then served
        pulse(1'b1, 1'b0);
        @(negedge clk);
        pulse(1'b0, 1'b1);
        chk("R7 still releasing", 32'(busy), 1);
        wait_idle();
        chk("R7 release done", 32'(bits()), 32'h0);
        @(negedge clk);
        chk("R7 held disable served", 32'(busy), 1);
        chk("R7 apply first step", 32'(bits()), 32'h4);
        wait_idle();
        chk("R7 apply done", 32'(bits()), 32'h7);

        // R7: enable and disable together, enable first
        pulse(1'b1, 1'b1);
        @(negedge clk);
        chk("R7 enable first", 32'(bits()), 32'h6);
        wait_idle();
        chk("R7 released", 32'(bits()), 32'h0);
        @(negedge clk);
        chk("R7 disable next", 32'(bits()), 32'h4);
        wait_idle();
        chk("R7 final bits", 32'(bits()), 32'h7);
        chk("R7 no underflow", 32'(underflow), 0);

        // R1: reset in the middle of a release
        pulse(1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid reset bits", 32'(bits()), 32'h7);
        chk("R1 mid reset busy", 32'(busy), 0);
        rst_n = 1'b1;
        repeat (S) @(negedge clk);
        chk("R1 stays idle", 32'(busy), 0);
        pulse(1'b0, 1'b1);
        @(negedge clk);
        chk("R1 count cleared", 32'(underflow), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule